// File: doc/BRIEF.md
# Asynchronous Memory Cycle Sequencer

This block turns single read or write requests from an internal bus into one cycle each on an external asynchronous memory bus. A cycle runs through three phases (setup, strobe, hold), and each phase lasts a programmed number of clock periods. Reads and writes have their own three counts. Each of four chip-select spaces keeps its own set of six counts in a timing register, written through a simple register write port.

Requests arrive on a valid/ready handshake that carries the space index, word address, byte enables, a write flag and write data. `req_ready` is high only while the block is idle. A request is taken on the rising edge where both `req_valid` and `req_ready` are high, and the requester must hold its fields stable until then. The response side has no back-pressure. `rsp_done` pulses for one clock when a cycle ends, and on reads `rsp_rdata` holds the captured word from that clock until the next read ends. The external device can add wait states by pulling `mem_rdy` low. That input passes through a synchronizer inside the block and stretches the strobe phase.

Top module: `amem_ctrl`

## Requirements
- R1: After reset all chip selects, byte enables, `mem_oe_n`, `mem_re_n` and `mem_we_n` are high, `mem_dq_oe` and `rsp_done` are low, and `req_ready` is high.
- R2: A clock with `cfg_we` high loads `cfg_data` into the timing register of space `cfg_sel`. Field layout, 4 bits each: [3:0] read setup, [7:4] read strobe, [11:8] read hold, [15:12] write setup, [19:16] write strobe, [23:20] write hold. All fields reset to 0.
- R3: Chip select, byte enables, address and (for reads) the output enable become valid in the clock after acceptance. They stay valid for exactly the effective setup count of clocks before the strobe goes low.
- R4: With `mem_rdy` high, the strobe (`mem_re_n` for reads, `mem_we_n` for writes) stays low for exactly the effective strobe count of clocks.
- R5: After the strobe rises, the select signals stay valid for exactly the effective hold count of clocks.
- R6: A field of 0 counts as 1. Any other value counts as itself.
- R7: `mem_rdy` passes through a two-stage synchronizer. If it rises in strobe clock c (counting from 1), the strobe ends after max(strobe count, c+2) clocks. A low level holds the strobe low.
- R8: On reads, `rsp_rdata` shows the value `mem_dq_in` had on the rising edge that ends the strobe.
- R9: During a cycle, exactly the chip select of the requested space is low (bit i of `mem_ce_n` for space i), `mem_be_n` is the inverse of the requested byte enables, and `mem_addr` is the requested address.
- R10: `mem_oe_n` is low for the whole of a read cycle and high in writes. `mem_dq_oe` is high for the whole of a write cycle and low otherwise, and `mem_dq_out` then carries the write data. The strobe of the other direction stays high.
- R11: `req_ready` is low from acceptance until the cycle ends. `rsp_done` is high for exactly one clock, the first clock after the hold phase, when all chip selects are high again.
- R12: Each space uses its own register, and the read or write counts are chosen by the request's write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_sel | input | 2 | Space whose timing register is written |
| cfg_data | input | 24 | Timing fields (layout in R2) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_cs | input | 2 | Space index of the request |
| req_addr | input | 20 | Word address |
| req_be | input | 4 | Byte enables, active high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-clock pulse when a cycle ends |
| rsp_rdata | output | 32 | Captured read data |
| mem_ce_n | output | 4 | Chip selects, active low |
| mem_be_n | output | 4 | Byte enables, active low |
| mem_addr | output | 20 | Word address |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 32 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 32 | Data from memory |
| mem_rdy | input | 1 | Ready from memory, asynchronous |

## Verification
The hardest case to reach from the ports is a strobe stretched by a late ready while the read data is still moving. The bench holds `mem_rdy` low into the strobe, raises it on a chosen strobe clock, and changes `mem_dq_in` one clock later. The strobe length must then show the two synchronizer stages, and the captured word must be the late value, which proves the capture happens on the strobe's last edge. Zero-valued fields and a space reprogrammed between cycles are reached by timing-register writes before the related requests.

// File: rtl/amem_pkg.sv
package amem_pkg;
  parameter int unsigned TW = 4;
  localparam int unsigned CTIM_W = 6 * TW;

  typedef logic [TW-1:0] tcnt_t;

  typedef struct packed {
    tcnt_t wr_hold;
    tcnt_t wr_strobe;
    tcnt_t wr_setup;
    tcnt_t rd_hold;
    tcnt_t rd_strobe;
    tcnt_t rd_setup;
  } ctim_t;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_t;

  // counter load value: a zero field acts as one clock
  function automatic tcnt_t cnt_load(tcnt_t v);
    return (v == '0) ? '0 : tcnt_t'(v - 1'b1);
  endfunction
endpackage

// File: rtl/amem_sync.sv
module amem_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/amem_treg.sv
module amem_treg
  import amem_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [CS_W-1:0]        sel,
  input  logic [CTIM_W-1:0]      wdata,
  output ctim_t [NUM_CS-1:0]     tim
);
  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_space
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          tim[i] <= '0;
        else if (we && (sel == CS_W'(i)))
          tim[i] <= ctim_t'(wdata);
      end
    end
  endgenerate
endmodule

// File: rtl/amem_phase.sv
module amem_phase
  import amem_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  ctim_t             tim,
  input  logic              rdy_s,
  input  logic [DATA_W-1:0] dq_in,
  output logic              busy,
  output logic              strobe,
  output logic              is_write,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  phase_t state;
  tcnt_t  cnt;
  tcnt_t  strobe_len;
  tcnt_t  hold_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PH_IDLE;
      cnt        <= '0;
      strobe_len <= '0;
      hold_len   <= '0;
      is_write   <= 1'b0;
      done       <= 1'b0;
      rdata      <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        PH_IDLE: begin
          if (start) begin
            state      <= PH_SETUP;
            is_write   <= start_write;
            cnt        <= cnt_load(start_write ? tim.wr_setup  : tim.rd_setup);
            strobe_len <= cnt_load(start_write ? tim.wr_strobe : tim.rd_strobe);
            hold_len   <= cnt_load(start_write ? tim.wr_hold   : tim.rd_hold);
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            state <= PH_STROBE;
            cnt   <= strobe_len;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (rdy_s) begin
            state <= PH_HOLD;
            cnt   <= hold_len;
            if (!is_write) rdata <= dq_in;
          end
        end
        PH_HOLD: begin
          if (cnt == '0) begin
            state <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (state != PH_IDLE);
  assign strobe = (state == PH_STROBE);

  AST_RDY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_STROBE && !rdy_s) |=> (state == PH_STROBE)); // R7

  AST_HOLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == PH_STROBE && state != PH_STROBE) |-> (state == PH_HOLD)); // R5

  AST_DONE_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(state) == PH_HOLD)); // R11
endmodule

// File: rtl/amem_ctrl.sv
module amem_ctrl
  import amem_pkg::*;
#(
  parameter int unsigned NUM_CS      = 4,
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned BE_W        = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CS_W-1:0]   cfg_sel,
  input  logic [CTIM_W-1:0] cfg_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NUM_CS-1:0] mem_ce_n,
  output logic [BE_W-1:0]   mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_oe_n,
  output logic              mem_re_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              mem_rdy
);
  ctim_t [NUM_CS-1:0] tim_all;
  logic               rdy_s;
  logic               busy;
  logic               strobe;
  logic               is_write;
  logic               accept;
  logic [CS_W-1:0]    cs_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [BE_W-1:0]    be_q;
  logic [DATA_W-1:0]  wdata_q;

  amem_treg #(.NUM_CS(NUM_CS)) i_treg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_data), .tim(tim_all)
  );

  amem_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_async(mem_rdy), .q_sync(rdy_s)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  amem_phase #(.DATA_W(DATA_W)) i_phase (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_write(req_write),
    .tim(tim_all[req_cs]), .rdy_s(rdy_s), .dq_in(mem_dq_in),
    .busy(busy), .strobe(strobe), .is_write(is_write),
    .done(rsp_done), .rdata(rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= '0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      cs_q    <= req_cs;
      addr_q  <= req_addr;
      be_q    <= req_be;
      wdata_q <= req_wdata;
    end
  end

  always_comb begin
    mem_ce_n = '1;
    if (busy) mem_ce_n[cs_q] = 1'b0;
  end

  assign mem_be_n   = busy ? ~be_q : '1;
  assign mem_addr   = addr_q;
  assign mem_oe_n   = !(busy && !is_write);
  assign mem_re_n   = !(strobe && !is_write);
  assign mem_we_n   = !(strobe && is_write);
  assign mem_dq_oe  = busy && is_write;
  assign mem_dq_out = wdata_q;

  AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_ce_n) <= 1); // R9

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_re_n && !mem_we_n)); // R10

  AST_DQ_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && mem_re_n)); // R10

  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_re_n) || $fell(mem_we_n)) |-> ($past(mem_ce_n) != '1)); // R3

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (mem_ce_n == '1 && req_ready)); // R11
endmodule

// File: tb/test_amem_ctrl.sv
module test_amem_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [23:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_cs = '0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic [3:0]  mem_ce_n;
  logic [3:0]  mem_be_n;
  logic [19:0] mem_addr;
  logic        mem_oe_n, mem_re_n, mem_we_n, mem_dq_oe;
  logic [31:0] mem_dq_out;
  logic [31:0] mem_dq_in = '0;
  logic        mem_rdy = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amem_ctrl i_amem_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs), .req_addr(req_addr),
    .req_be(req_be), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
    .mem_oe_n(mem_oe_n), .mem_re_n(mem_re_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_rdy(mem_rdy)
  );

  // timing words per space, layout of R2: [3:0] rs [7:4] rt [11:8] rh [15:12] ws [19:16] wt [23:20] wh
  localparam logic [23:0] CFG0 = 24'h232121;
  localparam logic [23:0] CFG1 = 24'h413000;
  localparam logic [23:0] CFG2 = 24'h111354;
  localparam logic [23:0] CFG3 = 24'h02F2F2;
  logic [23:0] cfg_model [4];

  typedef struct packed {
    logic [1:0]  cs;
    logic        wr;
    logic [19:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{cs: 2'd0, wr: 1'b0, addr: 20'h00010, be: 4'hF, data: 32'hA5A5_0001},
    '{cs: 2'd0, wr: 1'b1, addr: 20'h00011, be: 4'h3, data: 32'h1234_5678},
    '{cs: 2'd1, wr: 1'b0, addr: 20'hFFFFF, be: 4'h1, data: 32'h0BAD_F00D},
    '{cs: 2'd1, wr: 1'b1, addr: 20'h12345, be: 4'hC, data: 32'hCAFE_0002},
    '{cs: 2'd2, wr: 1'b0, addr: 20'h00000, be: 4'h8, data: 32'h5555_AAAA},
    '{cs: 2'd2, wr: 1'b1, addr: 20'h54321, be: 4'hF, data: 32'hFFFF_0000},
    '{cs: 2'd3, wr: 1'b0, addr: 20'h0F0F0, be: 4'h6, data: 32'h0000_FFFF},
    '{cs: 2'd3, wr: 1'b1, addr: 20'hABCDE, be: 4'h9, data: 32'hDEAD_BEEF}
  };

  function automatic int eff(input logic [3:0] v); // R6: zero counts as one
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] sel, input logic [23:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_model[sel] = val;
  endtask

  // rel_at = 0: ready high throughout; otherwise ready raised in that strobe clock
  task automatic run_txn(input vec_t v, input int rel_at, input logic [31:0] din_a, input logic [31:0] din_b);
    logic [23:0] c;
    int es, et, eh, s, t, h, phase;
    bit sel_ok, rdy_ok, dir_ok, done;
    logic [31:0] exp_rd;
    c = cfg_model[v.cs];
    es = eff(v.wr ? c[15:12] : c[3:0]);
    et = eff(v.wr ? c[19:16] : c[7:4]);
    eh = eff(v.wr ? c[23:20] : c[11:8]);
    if (rel_at > 0 && rel_at + 2 > et) et = rel_at + 2;
    exp_rd = (rel_at > 0) ? din_b : din_a;
    s = 0; t = 0; h = 0; phase = 0;
    sel_ok = 1; rdy_ok = 1; dir_ok = 1; done = 0;
    @(negedge clk);
    req_valid = 1'b1; req_cs = v.cs; req_write = v.wr; req_addr = v.addr;
    req_be = v.be; req_wdata = v.data; mem_dq_in = din_a; mem_rdy = (rel_at == 0);
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~v.data; req_addr = ~v.addr;
    for (int k = 0; k < 300 && !done; k++) begin
      if (rsp_done) begin
        done = 1;
      end else begin
        if (mem_ce_n != ~(4'b0001 << v.cs) || mem_be_n != ~v.be || mem_addr != v.addr) sel_ok = 0;
        if (req_ready) rdy_ok = 0;
        if (mem_oe_n != v.wr || mem_dq_oe != v.wr) dir_ok = 0;
        if (v.wr && mem_dq_out != v.data) dir_ok = 0;
        if ((v.wr && !mem_re_n) || (!v.wr && !mem_we_n)) dir_ok = 0;
        if ((v.wr ? mem_we_n : mem_re_n) == 1'b0) begin
          t++; phase = 1;
          if (rel_at > 0 && t == rel_at) mem_rdy = 1'b1;
          if (rel_at > 0 && t == rel_at + 1) mem_dq_in = din_b;
        end else if (phase == 0) s++;
        else h++;
        @(negedge clk);
      end
    end
    chk(done, "R11", "done pulse seen", done, 1);
    chk(s == es, "R3", "setup clocks", s, es);
    chk(t == et, (rel_at > 0) ? "R7" : "R4", "strobe clocks", t, et);
    chk(h == eh, "R5", "hold clocks", h, eh);
    chk(sel_ok, "R9", "select signals", sel_ok, 1);
    chk(dir_ok, "R10", "direction signals", dir_ok, 1);
    chk(rdy_ok, "R11", "ready low while busy", rdy_ok, 1);
    chk(mem_ce_n == 4'hF && req_ready, "R11", "idle at done", {mem_ce_n, req_ready}, 5'h1F);
    if (!v.wr) chk(rsp_rdata == exp_rd, "R8", "read data", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(!rsp_done, "R11", "done one clock", rsp_done, 0);
    mem_rdy = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) cfg_model[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_ce_n == 4'hF && mem_be_n == 4'hF, "R1", "selects idle", {mem_ce_n, mem_be_n}, 8'hFF);
    chk(mem_oe_n && mem_re_n && mem_we_n, "R1", "strobes idle", {mem_oe_n, mem_re_n, mem_we_n}, 3'h7);
    chk(!mem_dq_oe && !rsp_done && req_ready, "R1", "handshake idle", {mem_dq_oe, rsp_done, req_ready}, 3'h1);
    rst_n = 1'b1;
    // R2, R6: registers reset to zero, every phase one clock
    run_txn(VECS[0], 0, 32'h1111_2222, 32'h0);
    run_txn(VECS[7], 0, 32'h0, 32'h0);
    // R2, R12: program each space, then walk the table
    write_cfg(2'd0, CFG0);
    write_cfg(2'd1, CFG1);
    write_cfg(2'd2, CFG2);
    write_cfg(2'd3, CFG3);
    for (int i = 0; i < 8; i++) run_txn(VECS[i], 0, 32'h3C3C_0000 + 32'(i), 32'h0);
    // R7, R8: ready held low into the strobe, data changes late
    run_txn(VECS[0], 3, 32'h0101_0101, 32'h7E7E_7E7E);
    run_txn(VECS[4], 6, 32'h0202_0202, 32'h8181_8181);
    run_txn(VECS[1], 1, 32'h0, 32'h0);
    // R12: reprogram one space, other spaces unchanged
    write_cfg(2'd2, 24'h000000);
    run_txn(VECS[4], 0, 32'h4444_4444, 32'h0);
    run_txn(VECS[6], 0, 32'h5555_5555, 32'h0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule